// File: doc/BRIEF.md
# Home Directory Coherence Controller

This block keeps the coherence directory for the slice of shared memory owned by one cluster in a clustered multiprocessor. Each memory block has one directory entry. The entry records the block's state, the clusters that hold a read-only copy, the cluster that owns a modified copy, and the context of any transaction that is still open on that block. Clusters send requests here only after their own caches and their local cluster could not satisfy the access.

The controller takes one message per cycle from the network. It answers one cycle later with a single response message, which carries a destination mask so that one message can reach several clusters. Requests to blocks held only in memory, or held read-only, are answered from the local memory port. A request to a block that is modified in a remote cluster is forwarded to that owner. The owner sends the data straight to the requester and then reports back so that the entry can be closed. A read-exclusive request to a read-only block sends one invalidation message to every other holder and counts their acknowledgements before it grants ownership. An update-write refreshes every holder's copy in place.

While a block has a forward or an invalidation round open, it is busy, and any new request to it is refused with a negative acknowledgement. Other blocks are served normally in the meantime, so several transactions can be open at once. The memory array sits outside the block, behind a read/write port whose read data is available in the same cycle.

Top module: `home_dir_ctrl`

## Requirements
- R1: After reset every entry is Uncached (state code 0), no block is busy, and rsp_valid stays 0 until a request arrives. Memory contents are not touched by reset.
- R2: A read (req_kind 0) to a non-busy block that is Uncached or Shared answers the next cycle with shared data (rsp_kind 0) to the requester only, carrying the memory word. The requester is added to the holders and the entry becomes Shared (code 1).
- R3: A read to a non-busy Dirty block (code 2) sends a read forward (rsp_kind 2) to the owner only, with rsp_req set to the requester. It does not write memory, and it marks the block busy.
- R4: An owner report (req_kind 4) that closes a read forward writes req_data to memory, clears busy, and leaves the entry Shared with exactly the old owner and the requester as holders. It sends no response.
- R5: A read-exclusive (req_kind 1) to an Uncached block, or to a Shared block whose only holder is the requester, answers with an exclusive grant (rsp_kind 1) to the requester with the memory word. The entry becomes Dirty with the requester as owner.
- R6: A read-exclusive to a Shared block with other holders sends one invalidation (rsp_kind 3) whose mask holds every other holder and excludes the requester. The grant (rsp_kind 1, with rsp_req set to the requester) goes out in the cycle after the last invalidation acknowledgement (req_kind 5) and not before.
- R7: A read-exclusive to a non-busy Dirty block sends an exclusive forward (rsp_kind 7) to the owner. The owner report that closes it makes the requester the owner, leaves the entry Dirty, and does not write memory.
- R8: A read, read-exclusive, writeback or update-write to a busy block answers the next cycle with a negative acknowledgement (rsp_kind 4) to the requester only, and leaves the entry unchanged.
- R9: A writeback (req_kind 2) from the recorded owner of a Dirty block writes req_data to memory, makes the entry Uncached, and answers with a writeback acknowledgement (rsp_kind 6). A writeback from any other cluster, or to a block that is not Dirty, is refused with rsp_kind 4 and leaves memory unchanged.
- R10: An update-write (req_kind 3) to an Uncached or Shared block writes req_data to memory and sends an update (rsp_kind 5) with that data to all holders plus the writer, leaving the holder set unchanged. On a Dirty block it is refused with rsp_kind 4 and memory is unchanged.
- R11: An owner report or an invalidation acknowledgement for a block with no matching open transaction produces no response and no change.
- R12: A busy block does not hold up requests to other blocks. Each request gets its response exactly one cycle after it is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Incoming message present this cycle |
| req_kind | input | 3 | Incoming message code |
| req_src | input | $clog2(N_CLUSTERS) | Sending cluster index |
| req_blk | input | $clog2(N_BLOCKS) | Block index within this home |
| req_data | input | DATA_W | Data carried by writeback, update-write or owner report |
| rsp_valid | output | 1 | Outgoing message present |
| rsp_kind | output | 3 | Outgoing message code |
| rsp_dst | output | N_CLUSTERS | Destination cluster mask |
| rsp_req | output | $clog2(N_CLUSTERS) | Cluster on whose behalf the message is sent |
| rsp_blk | output | $clog2(N_BLOCKS) | Block index of the message |
| rsp_data | output | DATA_W | Data carried by the message |
| mem_addr | output | $clog2(N_BLOCKS) | Memory block address |
| mem_we | output | 1 | Memory write enable, taken at the clock edge |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data for mem_addr, same cycle |

## Verification
The bench builds the controller with its defaults: eight clusters, sixteen blocks and 32-bit data. Eight clusters make it possible to form holder sets of two and three, with the requester both inside and outside the set. That brings invalidation rounds with several acknowledgements, update-writes that reach many clusters, and forwards that name an arbitrary owner index within reach. Sixteen blocks let one block stay busy with a forward while requests to another block are served, and let a stray owner report land on a block that has nothing open.

// File: rtl/home_dir_pkg.sv
// home_dir_pkg: message and state codes shared by the home directory
// controller, its submodules and its checker. Assumes 3-bit message codes
// on both the request and response sides.
package home_dir_pkg;

    typedef enum logic [1:0] {
        DS_UNCACHED = 2'd0,
        DS_SHARED   = 2'd1,
        DS_DIRTY    = 2'd2
    } dir_state_e;

    typedef enum logic [2:0] {
        RQ_READ    = 3'd0,
        RQ_READX   = 3'd1,
        RQ_WBACK   = 3'd2,
        RQ_UPDW    = 3'd3,
        RQ_OWN_RPT = 3'd4,
        RQ_INV_ACK = 3'd5
    } req_kind_e;

    typedef enum logic [2:0] {
        RS_DATA   = 3'd0,
        RS_GRANT  = 3'd1,
        RS_FWD_RD = 3'd2,
        RS_INV    = 3'd3,
        RS_NACK   = 3'd4,
        RS_UPD    = 3'd5,
        RS_WB_ACK = 3'd6,
        RS_FWD_EX = 3'd7
    } rsp_kind_e;

endpackage

// File: rtl/dir_entry_array.sv
// dir_entry_array: storage for one directory entry per block. Each entry
// holds the coherence state, the holder mask, the owner index and the
// context of an open transaction (busy, forward-or-invalidate, exclusive,
// requester, outstanding acknowledgements). Assumes a single read index
// and a single write index per cycle; read is combinational.
module dir_entry_array #(
    parameter int NC = 8,
    parameter int NB = 16,
    parameter int CW = 3,
    parameter int BW = 4,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [BW-1:0] rd_idx,
    output logic [1:0]    rd_st,
    output logic [NC-1:0] rd_hold,
    output logic [CW-1:0] rd_own,
    output logic          rd_busy,
    output logic          rd_pfwd,
    output logic          rd_pexc,
    output logic [CW-1:0] rd_preq,
    output logic [AW-1:0] rd_acks,
    input  logic          wr_en,
    input  logic [BW-1:0] wr_idx,
    input  logic [1:0]    wr_st,
    input  logic [NC-1:0] wr_hold,
    input  logic [CW-1:0] wr_own,
    input  logic          wr_busy,
    input  logic          wr_pfwd,
    input  logic          wr_pexc,
    input  logic [CW-1:0] wr_preq,
    input  logic [AW-1:0] wr_acks
);
    logic [1:0]    st_q   [NB];
    logic [NC-1:0] hold_q [NB];
    logic [CW-1:0] own_q  [NB];
    logic          busy_q [NB];
    logic          pfwd_q [NB];
    logic          pexc_q [NB];
    logic [CW-1:0] preq_q [NB];
    logic [AW-1:0] acks_q [NB];

    // Entry update: clear everything on reset, else write the addressed entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NB; i++) begin
                st_q[i]   <= 2'd0;
                hold_q[i] <= '0;
                own_q[i]  <= '0;
                busy_q[i] <= 1'b0;
                pfwd_q[i] <= 1'b0;
                pexc_q[i] <= 1'b0;
                preq_q[i] <= '0;
                acks_q[i] <= '0;
            end
        end else if (wr_en) begin
            st_q[wr_idx]   <= wr_st;
            hold_q[wr_idx] <= wr_hold;
            own_q[wr_idx]  <= wr_own;
            busy_q[wr_idx] <= wr_busy;
            pfwd_q[wr_idx] <= wr_pfwd;
            pexc_q[wr_idx] <= wr_pexc;
            preq_q[wr_idx] <= wr_preq;
            acks_q[wr_idx] <= wr_acks;
        end
    end

    // Read port: present the addressed entry.
    always_comb begin
        rd_st   = st_q[rd_idx];
        rd_hold = hold_q[rd_idx];
        rd_own  = own_q[rd_idx];
        rd_busy = busy_q[rd_idx];
        rd_pfwd = pfwd_q[rd_idx];
        rd_pexc = pexc_q[rd_idx];
        rd_preq = preq_q[rd_idx];
        rd_acks = acks_q[rd_idx];
    end

endmodule

// File: rtl/dir_decide.sv
// dir_decide: combinational protocol engine. For the incoming message and
// the addressed directory entry it computes the new entry, the memory
// write, and the single outgoing message. Assumes the memory read data for
// the addressed block is valid in the same cycle.
module dir_decide
    import home_dir_pkg::*;
#(
    parameter int NC = 8,
    parameter int CW = 3,
    parameter int AW = 4,
    parameter int DW = 32
) (
    input  logic          req_valid,
    input  logic [2:0]    req_kind,
    input  logic [CW-1:0] req_src,
    input  logic [DW-1:0] req_data,
    input  logic [DW-1:0] mem_rdata,
    input  logic [1:0]    cur_st,
    input  logic [NC-1:0] cur_hold,
    input  logic [CW-1:0] cur_own,
    input  logic          cur_busy,
    input  logic          cur_pfwd,
    input  logic          cur_pexc,
    input  logic [CW-1:0] cur_preq,
    input  logic [AW-1:0] cur_acks,
    output logic          ent_we,
    output logic [1:0]    nxt_st,
    output logic [NC-1:0] nxt_hold,
    output logic [CW-1:0] nxt_own,
    output logic          nxt_busy,
    output logic          nxt_pfwd,
    output logic          nxt_pexc,
    output logic [CW-1:0] nxt_preq,
    output logic [AW-1:0] nxt_acks,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    output logic          o_valid,
    output logic [2:0]    o_kind,
    output logic [NC-1:0] o_mask,
    output logic [CW-1:0] o_req,
    output logic [DW-1:0] o_data
);
    logic [NC-1:0] src_oh;
    logic [NC-1:0] own_oh;
    logic [NC-1:0] preq_oh;
    logic [NC-1:0] others;
    logic [AW-1:0] n_others;
    dir_state_e    st;
    req_kind_e     kind;

    // One-hot decode of the cluster indices, one comparator per cluster.
    for (genvar g = 0; g < NC; g++) begin : g_decode
        assign src_oh[g]  = (req_src  == CW'(g));
        assign own_oh[g]  = (cur_own  == CW'(g));
        assign preq_oh[g] = (cur_preq == CW'(g));
    end

    assign st     = dir_state_e'(cur_st);
    assign kind   = req_kind_e'(req_kind);
    assign others = cur_hold & ~src_oh;

    // Count the holders that an exclusive request must invalidate.
    always_comb begin
        n_others = '0;
        for (int i = 0; i < NC; i++) begin
            n_others = n_others + AW'(others[i]);
        end
    end

    // Protocol decision for the current message.
    always_comb begin
        ent_we    = 1'b0;
        nxt_st    = cur_st;
        nxt_hold  = cur_hold;
        nxt_own   = cur_own;
        nxt_busy  = cur_busy;
        nxt_pfwd  = cur_pfwd;
        nxt_pexc  = cur_pexc;
        nxt_preq  = cur_preq;
        nxt_acks  = cur_acks;
        mem_we    = 1'b0;
        mem_wdata = req_data;
        o_valid   = 1'b0;
        o_kind    = RS_NACK;
        o_mask    = src_oh;
        o_req     = req_src;
        o_data    = mem_rdata;
        if (req_valid) begin
            case (kind)
                RQ_READ: begin
                    o_valid = 1'b1;
                    if (cur_busy) begin
                        o_kind = RS_NACK;
                    end else if (st == DS_DIRTY) begin
                        o_kind   = RS_FWD_RD;
                        o_mask   = own_oh;
                        ent_we   = 1'b1;
                        nxt_busy = 1'b1;
                        nxt_pfwd = 1'b1;
                        nxt_pexc = 1'b0;
                        nxt_preq = req_src;
                    end else begin
                        o_kind   = RS_DATA;
                        ent_we   = 1'b1;
                        nxt_st   = DS_SHARED;
                        nxt_hold = cur_hold | src_oh;
                    end
                end
                RQ_READX: begin
                    o_valid = 1'b1;
                    if (cur_busy) begin
                        o_kind = RS_NACK;
                    end else if (st == DS_DIRTY) begin
                        o_kind   = RS_FWD_EX;
                        o_mask   = own_oh;
                        ent_we   = 1'b1;
                        nxt_busy = 1'b1;
                        nxt_pfwd = 1'b1;
                        nxt_pexc = 1'b1;
                        nxt_preq = req_src;
                    end else if (st == DS_SHARED && others != '0) begin
                        o_kind   = RS_INV;
                        o_mask   = others;
                        ent_we   = 1'b1;
                        nxt_busy = 1'b1;
                        nxt_pfwd = 1'b0;
                        nxt_pexc = 1'b1;
                        nxt_preq = req_src;
                        nxt_acks = n_others;
                    end else begin
                        o_kind   = RS_GRANT;
                        ent_we   = 1'b1;
                        nxt_st   = DS_DIRTY;
                        nxt_own  = req_src;
                        nxt_hold = '0;
                    end
                end
                RQ_WBACK: begin
                    o_valid = 1'b1;
                    if (!cur_busy && st == DS_DIRTY && cur_own == req_src) begin
                        o_kind   = RS_WB_ACK;
                        mem_we   = 1'b1;
                        ent_we   = 1'b1;
                        nxt_st   = DS_UNCACHED;
                        nxt_hold = '0;
                    end else begin
                        o_kind = RS_NACK;
                    end
                end
                RQ_UPDW: begin
                    o_valid = 1'b1;
                    if (!cur_busy && st != DS_DIRTY) begin
                        o_kind = RS_UPD;
                        o_mask = cur_hold | src_oh;
                        o_data = req_data;
                        mem_we = 1'b1;
                    end else begin
                        o_kind = RS_NACK;
                    end
                end
                RQ_OWN_RPT: begin
                    if (cur_busy && cur_pfwd) begin
                        ent_we   = 1'b1;
                        nxt_busy = 1'b0;
                        nxt_pfwd = 1'b0;
                        if (cur_pexc) begin
                            nxt_st  = DS_DIRTY;
                            nxt_own = cur_preq;
                        end else begin
                            mem_we   = 1'b1;
                            nxt_st   = DS_SHARED;
                            nxt_hold = own_oh | preq_oh;
                        end
                    end
                end
                RQ_INV_ACK: begin
                    if (cur_busy && !cur_pfwd) begin
                        ent_we   = 1'b1;
                        nxt_acks = cur_acks - 1'b1;
                        if (cur_acks == AW'(1)) begin
                            nxt_busy = 1'b0;
                            nxt_st   = DS_DIRTY;
                            nxt_own  = cur_preq;
                            nxt_hold = '0;
                            o_valid  = 1'b1;
                            o_kind   = RS_GRANT;
                            o_mask   = preq_oh;
                            o_req    = cur_preq;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/rsp_reg.sv
// rsp_reg: output register for the single outgoing message. Assumes the
// network accepts one message per cycle; valid is cleared on reset.
module rsp_reg #(
    parameter int NC = 8,
    parameter int CW = 3,
    parameter int BW = 4,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          d_valid,
    input  logic [2:0]    d_kind,
    input  logic [NC-1:0] d_mask,
    input  logic [CW-1:0] d_req,
    input  logic [BW-1:0] d_blk,
    input  logic [DW-1:0] d_data,
    output logic          q_valid,
    output logic [2:0]    q_kind,
    output logic [NC-1:0] q_mask,
    output logic [CW-1:0] q_req,
    output logic [BW-1:0] q_blk,
    output logic [DW-1:0] q_data
);
    // Capture the message decided this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q_kind  <= '0;
            q_mask  <= '0;
            q_req   <= '0;
            q_blk   <= '0;
            q_data  <= '0;
        end else begin
            q_valid <= d_valid;
            q_kind  <= d_kind;
            q_mask  <= d_mask;
            q_req   <= d_req;
            q_blk   <= d_blk;
            q_data  <= d_data;
        end
    end

endmodule

// File: rtl/home_dir_ctrl.sv
// home_dir_ctrl: home directory controller for one cluster's memory slice.
// It accepts one coherence message per cycle and answers the cycle after.
// It serves data from memory, forwards to a remote owner, or runs an
// invalidation round. Assumes the external memory returns read data
// combinationally for mem_addr and writes on the clock edge when mem_we is set.
module home_dir_ctrl #(
    parameter int N_CLUSTERS = 8,
    parameter int N_BLOCKS   = 16,
    parameter int DATA_W     = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic [2:0]                    req_kind,
    input  logic [$clog2(N_CLUSTERS)-1:0] req_src,
    input  logic [$clog2(N_BLOCKS)-1:0]   req_blk,
    input  logic [DATA_W-1:0]             req_data,
    output logic                          rsp_valid,
    output logic [2:0]                    rsp_kind,
    output logic [N_CLUSTERS-1:0]         rsp_dst,
    output logic [$clog2(N_CLUSTERS)-1:0] rsp_req,
    output logic [$clog2(N_BLOCKS)-1:0]   rsp_blk,
    output logic [DATA_W-1:0]             rsp_data,
    output logic [$clog2(N_BLOCKS)-1:0]   mem_addr,
    output logic                          mem_we,
    output logic [DATA_W-1:0]             mem_wdata,
    input  logic [DATA_W-1:0]             mem_rdata
);
    localparam int CW = $clog2(N_CLUSTERS);
    localparam int BW = $clog2(N_BLOCKS);
    localparam int AW = $clog2(N_CLUSTERS + 1);

    logic [1:0]          cur_st,   nxt_st;
    logic [N_CLUSTERS-1:0] cur_hold, nxt_hold;
    logic [CW-1:0]       cur_own,  nxt_own;
    logic                cur_busy, nxt_busy;
    logic                cur_pfwd, nxt_pfwd;
    logic                cur_pexc, nxt_pexc;
    logic [CW-1:0]       cur_preq, nxt_preq;
    logic [AW-1:0]       cur_acks, nxt_acks;
    logic                ent_we;
    logic                o_valid;
    logic [2:0]          o_kind;
    logic [N_CLUSTERS-1:0] o_mask;
    logic [CW-1:0]       o_req;
    logic [DATA_W-1:0]   o_data;

    assign mem_addr = req_blk;

    dir_entry_array #(
        .NC(N_CLUSTERS), .NB(N_BLOCKS), .CW(CW), .BW(BW), .AW(AW)
    ) u_entries (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (req_blk),
        .rd_st   (cur_st),
        .rd_hold (cur_hold),
        .rd_own  (cur_own),
        .rd_busy (cur_busy),
        .rd_pfwd (cur_pfwd),
        .rd_pexc (cur_pexc),
        .rd_preq (cur_preq),
        .rd_acks (cur_acks),
        .wr_en   (ent_we),
        .wr_idx  (req_blk),
        .wr_st   (nxt_st),
        .wr_hold (nxt_hold),
        .wr_own  (nxt_own),
        .wr_busy (nxt_busy),
        .wr_pfwd (nxt_pfwd),
        .wr_pexc (nxt_pexc),
        .wr_preq (nxt_preq),
        .wr_acks (nxt_acks)
    );

    dir_decide #(
        .NC(N_CLUSTERS), .CW(CW), .AW(AW), .DW(DATA_W)
    ) u_decide (
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .req_src   (req_src),
        .req_data  (req_data),
        .mem_rdata (mem_rdata),
        .cur_st    (cur_st),
        .cur_hold  (cur_hold),
        .cur_own   (cur_own),
        .cur_busy  (cur_busy),
        .cur_pfwd  (cur_pfwd),
        .cur_pexc  (cur_pexc),
        .cur_preq  (cur_preq),
        .cur_acks  (cur_acks),
        .ent_we    (ent_we),
        .nxt_st    (nxt_st),
        .nxt_hold  (nxt_hold),
        .nxt_own   (nxt_own),
        .nxt_busy  (nxt_busy),
        .nxt_pfwd  (nxt_pfwd),
        .nxt_pexc  (nxt_pexc),
        .nxt_preq  (nxt_preq),
        .nxt_acks  (nxt_acks),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .o_valid   (o_valid),
        .o_kind    (o_kind),
        .o_mask    (o_mask),
        .o_req     (o_req),
        .o_data    (o_data)
    );

    rsp_reg #(
        .NC(N_CLUSTERS), .CW(CW), .BW(BW), .DW(DATA_W)
    ) u_rsp (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_valid (o_valid),
        .d_kind  (o_kind),
        .d_mask  (o_mask),
        .d_req   (o_req),
        .d_blk   (req_blk),
        .d_data  (o_data),
        .q_valid (rsp_valid),
        .q_kind  (rsp_kind),
        .q_mask  (rsp_dst),
        .q_req   (rsp_req),
        .q_blk   (rsp_blk),
        .q_data  (rsp_data)
    );

endmodule

// File: rtl/home_dir_ctrl_chk.sv
// home_dir_ctrl_chk: protocol checker bound to home_dir_ctrl. It watches
// only the ports and relates incoming messages, memory writes and outgoing
// messages over time.
module home_dir_ctrl_chk
    import home_dir_pkg::*;
#(
    parameter int N_CLUSTERS = 8,
    parameter int N_BLOCKS   = 16,
    parameter int DATA_W     = 32
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          req_valid,
    input logic [2:0]                    req_kind,
    input logic [$clog2(N_CLUSTERS)-1:0] req_src,
    input logic                          rsp_valid,
    input logic [2:0]                    rsp_kind,
    input logic [N_CLUSTERS-1:0]         rsp_dst,
    input logic [$clog2(N_CLUSTERS)-1:0] rsp_req,
    input logic                          mem_we
);
    // R1: nothing goes out in the first cycle after reset.
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !rsp_valid);

    // R12: every request that expects an answer gets one the next cycle.
    a_r12_answer_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind <= 3'd3) |=> rsp_valid);

    // R8: a refusal goes to exactly one cluster.
    a_r8_nack_single_dst: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == RS_NACK) |-> $onehot(rsp_dst));

    // R5: data and grants go to exactly one cluster.
    a_r5_data_single_dst: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_kind == RS_DATA || rsp_kind == RS_GRANT)) |-> $onehot(rsp_dst));

    // R6: an invalidation never targets the requester and is never empty.
    a_r6_inv_skips_requester: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == RS_INV) |-> (rsp_dst != '0 && !rsp_dst[rsp_req]));

    // R10: an update always reaches the writer.
    a_r10_upd_reaches_writer: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == RS_UPD) |-> rsp_dst[rsp_req]);

    // R3: forwarding never writes memory in the deciding cycle.
    a_r3_fwd_no_mem_write: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_kind == RS_FWD_RD || rsp_kind == RS_FWD_EX)) |-> !$past(mem_we));

    // R3: a forward goes to the single owner.
    a_r3_fwd_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_kind == RS_FWD_RD || rsp_kind == RS_FWD_EX)) |-> $onehot(rsp_dst));

endmodule

bind home_dir_ctrl home_dir_ctrl_chk #(
    .N_CLUSTERS(N_CLUSTERS), .N_BLOCKS(N_BLOCKS), .DATA_W(DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .req_src   (req_src),
    .rsp_valid (rsp_valid),
    .rsp_kind  (rsp_kind),
    .rsp_dst   (rsp_dst),
    .rsp_req   (rsp_req),
    .mem_we    (mem_we)
);

// File: tb/home_dir_ctrl_bench.sv
// home_dir_ctrl_bench: table-driven bench for home_dir_ctrl followed by
// directed reset checks. Memory is modelled in the bench.
module home_dir_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 8;
    localparam int NB = 16;
    localparam int DW = 32;
    localparam int WATCHDOG_CYCLES = 20000;

    localparam logic [2:0] K_RD = 3'd0, K_RX = 3'd1, K_WB = 3'd2, K_UP = 3'd3,
                           K_FD = 3'd4, K_IA = 3'd5;
    localparam logic [2:0] S_DATA = 3'd0, S_GRANT = 3'd1, S_FRD = 3'd2, S_INV = 3'd3,
                           S_NACK = 3'd4, S_UPD = 3'd5, S_WBA = 3'd6, S_FEX = 3'd7;

    typedef struct packed {
        logic [2:0]  kind;
        logic [2:0]  src;
        logic [3:0]  blk;
        logic [31:0] data;
        logic        ev;
        logic [2:0]  ek;
        logic [7:0]  em;
        logic [31:0] ed;
        logic [2:0]  erq;
        logic        mchk;
        logic [31:0] emem;
        logic [7:0]  tag;
    } vec_t;

    localparam int NV = 31;
    localparam vec_t TBL [NV] = '{
        '{K_RD,3'd1,4'd0,32'h0,       1'b1,S_DATA, 8'h02,32'h10000000,3'd0,1'b0,32'h0,       8'd2},  // R2
        '{K_RD,3'd2,4'd0,32'h0,       1'b1,S_DATA, 8'h04,32'h10000000,3'd0,1'b0,32'h0,       8'd2},  // R2
        '{K_UP,3'd3,4'd0,32'hCAFE0000,1'b1,S_UPD,  8'h0E,32'hCAFE0000,3'd3,1'b1,32'hCAFE0000,8'd10}, // R10
        '{K_RD,3'd4,4'd0,32'h0,       1'b1,S_DATA, 8'h10,32'hCAFE0000,3'd0,1'b0,32'h0,       8'd2},  // R2
        '{K_RX,3'd1,4'd0,32'h0,       1'b1,S_INV,  8'h14,32'h0,       3'd1,1'b0,32'h0,       8'd6},  // R6
        '{K_RD,3'd5,4'd0,32'h0,       1'b1,S_NACK, 8'h20,32'h0,       3'd0,1'b0,32'h0,       8'd8},  // R8
        '{K_IA,3'd2,4'd0,32'h0,       1'b0,S_DATA, 8'h00,32'h0,       3'd0,1'b0,32'h0,       8'd6},  // R6
        '{K_IA,3'd4,4'd0,32'h0,       1'b1,S_GRANT,8'h02,32'hCAFE0000,3'd1,1'b0,32'h0,       8'd6},  // R6
        '{K_IA,3'd4,4'd0,32'h0,       1'b0,S_DATA, 8'h00,32'h0,       3'd0,1'b0,32'h0,       8'd11}, // R11
        '{K_RD,3'd6,4'd0,32'h0,       1'b1,S_FRD,  8'h02,32'h0,       3'd6,1'b0,32'h0,       8'd3},  // R3
        '{K_RD,3'd7,4'd3,32'h0,       1'b1,S_DATA, 8'h80,32'h10000003,3'd0,1'b0,32'h0,       8'd12}, // R12
        '{K_WB,3'd1,4'd0,32'h0,       1'b1,S_NACK, 8'h02,32'h0,       3'd0,1'b1,32'hCAFE0000,8'd8},  // R8
        '{K_FD,3'd1,4'd0,32'hBEEF0001,1'b0,S_DATA, 8'h00,32'h0,       3'd0,1'b1,32'hBEEF0001,8'd4},  // R4
        '{K_RD,3'd2,4'd0,32'h0,       1'b1,S_DATA, 8'h04,32'hBEEF0001,3'd0,1'b0,32'h0,       8'd4},  // R4
        '{K_RX,3'd2,4'd0,32'h0,       1'b1,S_INV,  8'h42,32'h0,       3'd2,1'b0,32'h0,       8'd4},  // R4
        '{K_IA,3'd1,4'd0,32'h0,       1'b0,S_DATA, 8'h00,32'h0,       3'd0,1'b0,32'h0,       8'd6},  // R6
        '{K_IA,3'd6,4'd0,32'h0,       1'b1,S_GRANT,8'h04,32'hBEEF0001,3'd2,1'b0,32'h0,       8'd6},  // R6
        '{K_RX,3'd3,4'd5,32'h0,       1'b1,S_GRANT,8'h08,32'h10000005,3'd3,1'b0,32'h0,       8'd5},  // R5
        '{K_RX,3'd0,4'd5,32'h0,       1'b1,S_FEX,  8'h08,32'h0,       3'd0,1'b0,32'h0,       8'd7},  // R7
        '{K_FD,3'd3,4'd5,32'h12345678,1'b0,S_DATA, 8'h00,32'h0,       3'd0,1'b1,32'h10000005,8'd7},  // R7
        '{K_RD,3'd4,4'd5,32'h0,       1'b1,S_FRD,  8'h01,32'h0,       3'd4,1'b0,32'h0,       8'd7},  // R7
        '{K_FD,3'd0,4'd5,32'h55550005,1'b0,S_DATA, 8'h00,32'h0,       3'd0,1'b1,32'h55550005,8'd4},  // R4
        '{K_WB,3'd3,4'd5,32'h0,       1'b1,S_NACK, 8'h08,32'h0,       3'd0,1'b1,32'h55550005,8'd9},  // R9
        '{K_RD,3'd2,4'd9,32'h0,       1'b1,S_DATA, 8'h04,32'h10000009,3'd0,1'b0,32'h0,       8'd2},  // R2
        '{K_RX,3'd2,4'd9,32'h0,       1'b1,S_GRANT,8'h04,32'h10000009,3'd2,1'b0,32'h0,       8'd5},  // R5
        '{K_UP,3'd2,4'd9,32'h0000AAAA,1'b1,S_NACK, 8'h04,32'h0,       3'd0,1'b1,32'h10000009,8'd10}, // R10
        '{K_FD,3'd5,4'd9,32'h0000BBBB,1'b0,S_DATA, 8'h00,32'h0,       3'd0,1'b1,32'h10000009,8'd11}, // R11
        '{K_WB,3'd3,4'd9,32'h0000CCCC,1'b1,S_NACK, 8'h08,32'h0,       3'd0,1'b1,32'h10000009,8'd9},  // R9
        '{K_WB,3'd2,4'd9,32'h99990009,1'b1,S_WBA,  8'h04,32'h0,       3'd0,1'b1,32'h99990009,8'd9},  // R9
        '{K_RD,3'd6,4'd9,32'h0,       1'b1,S_DATA, 8'h40,32'h99990009,3'd0,1'b0,32'h0,       8'd9},  // R9
        '{K_RX,3'd6,4'd9,32'h0,       1'b1,S_GRANT,8'h40,32'h99990009,3'd6,1'b0,32'h0,       8'd5}   // R5
    };

    logic          clk;
    logic          rst_n;
    logic          req_valid;
    logic [2:0]    req_kind;
    logic [2:0]    req_src;
    logic [3:0]    req_blk;
    logic [DW-1:0] req_data;
    logic          rsp_valid;
    logic [2:0]    rsp_kind;
    logic [NC-1:0] rsp_dst;
    logic [2:0]    rsp_req;
    logic [3:0]    rsp_blk;
    logic [DW-1:0] rsp_data;
    logic [3:0]    mem_addr;
    logic          mem_we;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;
    logic [DW-1:0] mem [NB];

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    home_dir_ctrl #(.N_CLUSTERS(NC), .N_BLOCKS(NB), .DATA_W(DW)) u_home_dir_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_kind(req_kind), .req_src(req_src),
        .req_blk(req_blk), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_dst(rsp_dst),
        .rsp_req(rsp_req), .rsp_blk(rsp_blk), .rsp_data(rsp_data),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    // Clock.
    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // Memory model: combinational read, write on the clock edge.
    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
    end

    task automatic drive(input logic [2:0] k, input logic [2:0] s,
                         input logic [3:0] b, input logic [31:0] d);
        req_valid = 1'b1;
        req_kind  = k;
        req_src   = s;
        req_blk   = b;
        req_data  = d;
    endtask

    task automatic check_vec(input vec_t v);
        bit ok;
        ok = (rsp_valid == v.ev);
        if (v.ev && ok) begin
            if (rsp_kind != v.ek || rsp_dst != v.em || rsp_blk != v.blk) ok = 1'b0;
            if ((v.ek == S_DATA || v.ek == S_GRANT || v.ek == S_UPD) && rsp_data != v.ed) ok = 1'b0;
            if ((v.ek == S_FRD || v.ek == S_FEX || v.ek == S_INV || v.ek == S_GRANT) &&
                v.ek != S_GRANT && rsp_req != v.erq) ok = 1'b0;
            if (v.ek == S_GRANT && rsp_req != v.erq && v.erq != 3'd0) ok = 1'b0;
        end
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d rsp actual valid=%0b kind=%0d dst=%02h req=%0d data=%08h expected valid=%0b kind=%0d dst=%02h req=%0d data=%08h",
                     v.tag, rsp_valid, rsp_kind, rsp_dst, rsp_req, rsp_data,
                     v.ev, v.ek, v.em, v.erq, v.ed);
        end
        if (v.mchk) begin
            n_checks++;
            if (mem[v.blk] != v.emem) begin
                n_fail++;
                $display("FAIL R%0d memory[%0d] actual=%08h expected=%08h",
                         v.tag, v.blk, mem[v.blk], v.emem);
            end
        end
    endtask

    task automatic check_idle(input string what);
        n_checks++;
        if (rsp_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 %s rsp_valid actual=%0b expected=0", what, rsp_valid);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R12 watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    // Main sequence: reset, table walk, directed reset corner.
    initial begin
        vec_t pr;
        for (int i = 0; i < NB; i++) mem[i] = 32'h10000000 + i;
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_kind  = '0;
        req_src   = '0;
        req_blk   = '0;
        req_data  = '0;
        repeat (3) @(negedge clk);
        check_idle("in reset");                       // R1
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("after reset");                    // R1

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].kind, TBL[i].src, TBL[i].blk, TBL[i].data);
            @(negedge clk);
            req_valid = 1'b0;
            check_vec(TBL[i]);
        end

        // R1: a second reset returns block 0 (left Dirty, owner 2) to Uncached.
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check_idle("second reset");
        rst_n = 1'b1;
        @(negedge clk);
        drive(K_RX, 3'd4, 4'd0, 32'h0);
        @(negedge clk);
        req_valid = 1'b0;
        pr = '{K_RX,3'd4,4'd0,32'h0,1'b1,S_GRANT,8'h10,32'hBEEF0001,3'd4,1'b1,32'hBEEF0001,8'd1};
        check_vec(pr);                                // R1
        @(negedge clk);
        check_idle("idle cycle after grant");         // R1

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule